// File: doc/BRIEF.md
# Output Voltage Fault Response Controller

This block watches the output of a switching regulator through two digital comparator flags, one for overvoltage and one for undervoltage. It also watches a digitized feedback code that is compared against a fixed overvoltage threshold. The fixed threshold is one of two codes. The level of a strap input, captured in the first clock after reset, picks which one. Every comparator path is synchronized and must stay high for a programmable number of clocks before a fault is declared.

Each fault class has its own response policy: ignore, latch off, or hiccup. Under ignore, switching continues and only the status bit records the event. Under latch, the power stage stays off until an external reset arrives while the bias supply is valid. Under hiccup, the power stage stays off for a programmable number of clocks and then restarts. An overvoltage fault holds the low-side switch on to discharge the output. An undervoltage fault turns both switches off. When the regulator returns to normal operation, the block issues a one-cycle restart request so that soft-start runs again.

Status bits are sticky per fault source. An alert output is raised while any status bit whose class is unmasked is set.

Top module: `vout_fault_ctrl`

## Requirements
- R1: After reset with the bias supply valid, the switching enable is high, both force outputs and the restart request are low, and all status bits and the alert are low.
- R2: Overvoltage detection is armed whenever the bias supply is valid, even while the soft-start-done flag is low.
- R3: While the soft-start-done flag is low, the undervoltage comparator is ignored: no status bit and no change in the power-stage drive.
- R4: An overvoltage fault whose response is latch or hiccup drops the switching enable and raises the force-low-side output, with the force-both-off output low.
- R5: An undervoltage fault whose response is latch or hiccup drops the switching enable and raises the force-both-off output, with the force-low-side output low.
- R6: The response code 0 means ignore. With code 0, a fault sets its status bit, but the switching enable stays high and both force outputs stay low.
- R7: Response code 1 means latch, and code 3 behaves like code 1. A latched fault holds its drive until the external reset is seen while the bias supply is valid. An external reset while the bias supply is low has no effect.
- R8: Response code 2 means hiccup. The fault drive is held for hiccupLen+1 clocks, and then the block returns to switching with a restart request pulse exactly one clock wide.
- R9: A comparator level that is high for fewer clocks than the filter length declares no fault and sets no status bit.
- R10: Status bits stay set until a clear-faults pulse. The alert equals the OR of the overvoltage bits (normal and fixed) gated by the overvoltage mask, and the undervoltage bit gated by the undervoltage mask.
- R11: If overvoltage and undervoltage are declared in the same cycle, the overvoltage drive wins and both status bits are set.
- R12: The fixed overvoltage check trips when the feedback code exceeds FIX_HI_CODE if the strap was high at power-up, or FIX_LO_CODE if it was low. Changes on the strap after power-up have no effect. A fixed trip uses the overvoltage response and mask.
- R13: An overvoltage fault that is not ignored preempts an undervoltage hold that is already active, turning the drive into force-low-side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| biasOk | input | 1 | Internal bias supply valid |
| ssDone | input | 1 | Soft-start finished |
| ovCmp | input | 1 | Overvoltage comparator flag (asynchronous) |
| uvCmp | input | 1 | Undervoltage comparator flag (asynchronous) |
| fbCode | input | THR_W | Digitized feedback level for the fixed check |
| strapHi | input | 1 | Threshold strap, captured once after reset |
| ovResp | input | 2 | Overvoltage policy: 0 ignore, 1/3 latch, 2 hiccup |
| uvResp | input | 2 | Undervoltage policy, same coding |
| ovMask | input | 1 | Masks overvoltage bits from the alert |
| uvMask | input | 1 | Masks the undervoltage bit from the alert |
| filtLen | input | FILT_W | Clocks a comparator must stay high |
| hiccupLen | input | HIC_W | Hiccup off time in clocks |
| clearFaults | input | 1 | Pulse that clears status bits |
| extReset | input | 1 | External reset that leaves a latched state |
| swEnable | output | 1 | Normal switching allowed |
| forceLowOn | output | 1 | Hold the low-side switch on |
| forceAllOff | output | 1 | Hold both switches off |
| restartReq | output | 1 | One-clock request to rerun soft-start |
| ovFlag | output | 1 | Sticky overvoltage status |
| uvFlag | output | 1 | Sticky undervoltage status |
| fixFlag | output | 1 | Sticky fixed-threshold overvoltage status |
| alert | output | 1 | Alert, high while an unmasked status bit is set |

## Verification
The overvoltage and undervoltage detectors can both declare a fault on the same clock. In that case the control must pick a single drive. The bench provokes this by raising both comparator flags on the same falling edge, with soft-start done and both policies set to latch. It then expects force-low-side high, force-both-off low, and both status bits set. A related case is an overvoltage that arrives while an undervoltage hold is already active. The bench checks that the drive switches to force-low-side.

// File: rtl/vfc_pkg.sv
`timescale 1ns/1ps
package vfc_pkg;
  localparam logic [1:0] RESP_IGNORE = 2'd0;
  localparam logic [1:0] RESP_LATCH  = 2'd1;
  localparam logic [1:0] RESP_HICCUP = 2'd2;

  localparam int CH_OV  = 0;
  localparam int CH_UV  = 1;
  localparam int CH_FIX = 2;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {ST_RUN, ST_LATCH, ST_HICCUP} ctlState_t;
  typedef enum logic {K_OV, K_UV} faultKind_t;

  typedef struct packed {
    logic hicLoad;
    logic hicStep;
  } ctlStrobe_t;
endpackage

// File: rtl/vfc_filter.sv
`timescale 1ns/1ps
module vfc_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             raw,
  input  logic [CNT_W-1:0] len,
  output logic             det
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!raw)      cnt <= '0;
    else if (cnt < len) cnt <= cnt + 1'b1;
  end

  assign det = raw && (cnt >= len);
endmodule

// File: rtl/vfc_datapath.sv
`timescale 1ns/1ps
module vfc_datapath
  import vfc_pkg::*;
#(
  parameter int FILT_W = 8,
  parameter int HIC_W  = 16,
  parameter int THR_W  = 8,
  parameter logic [THR_W-1:0] FIX_HI_CODE = 220,
  parameter logic [THR_W-1:0] FIX_LO_CODE = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              biasOk,
  input  logic              ssDone,
  input  logic              ovCmp,
  input  logic              uvCmp,
  input  logic [THR_W-1:0]  fbCode,
  input  logic              strapHi,
  input  logic              ovMask,
  input  logic              uvMask,
  input  logic [FILT_W-1:0] filtLen,
  input  logic [HIC_W-1:0]  hiccupLen,
  input  logic              clearFaults,
  input  ctlStrobe_t        stb,
  output logic              ovDet,
  output logic              uvDet,
  output logic              hicDone,
  output logic              ovFlag,
  output logic              uvFlag,
  output logic              fixFlag,
  output logic              alert
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] ovSyncQ, uvSyncQ;
  logic              strapTaken, strapSel, fixHitQ;
  logic [THR_W-1:0]  fixThr;
  logic [NUM_CH-1:0] chRaw, chDet;
  logic [HIC_W-1:0]  hicCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovSyncQ <= '0;
      uvSyncQ <= '0;
    end else begin
      ovSyncQ <= {ovSyncQ[SYNC_N-2:0], ovCmp};
      uvSyncQ <= {uvSyncQ[SYNC_N-2:0], uvCmp};
    end
  end

  // strap captured once, on the first edge after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapTaken <= 1'b0;
      strapSel   <= 1'b0;
    end else if (!strapTaken) begin
      strapTaken <= 1'b1;
      strapSel   <= strapHi;
    end
  end

  assign fixThr = strapSel ? FIX_HI_CODE : FIX_LO_CODE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fixHitQ <= 1'b0;
    else       fixHitQ <= strapTaken && (fbCode > fixThr);
  end

  assign chRaw[CH_OV]  = biasOk && ovSyncQ[SYNC_N-1];
  assign chRaw[CH_UV]  = biasOk && ssDone && uvSyncQ[SYNC_N-1];
  assign chRaw[CH_FIX] = biasOk && fixHitQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_filt
    vfc_filter #(.CNT_W(FILT_W)) u_filt (
      .clk (clk),
      .rstN(rstN),
      .raw (chRaw[i]),
      .len (filtLen),
      .det (chDet[i])
    );
  end

  assign ovDet = chDet[CH_OV] | chDet[CH_FIX];
  assign uvDet = chDet[CH_UV];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovFlag  <= 1'b0;
      uvFlag  <= 1'b0;
      fixFlag <= 1'b0;
    end else begin
      ovFlag  <= chDet[CH_OV]  | (ovFlag  & ~clearFaults);
      uvFlag  <= chDet[CH_UV]  | (uvFlag  & ~clearFaults);
      fixFlag <= chDet[CH_FIX] | (fixFlag & ~clearFaults);
    end
  end

  assign alert = ((ovFlag | fixFlag) & ~ovMask) | (uvFlag & ~uvMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       hicCnt <= '0;
    else if (stb.hicLoad)            hicCnt <= '0;
    else if (stb.hicStep && !hicDone) hicCnt <= hicCnt + 1'b1;
  end

  assign hicDone = hicCnt >= hiccupLen;

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovFlag && !clearFaults) |=> ovFlag);

  // R3
  uv_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ssDone |=> !$rose(uvFlag));
endmodule

// File: rtl/vfc_control.sv
`timescale 1ns/1ps
module vfc_control
  import vfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       biasOk,
  input  logic       ovDet,
  input  logic       uvDet,
  input  logic       hicDone,
  input  logic [1:0] ovResp,
  input  logic [1:0] uvResp,
  input  logic       extReset,
  output ctlStrobe_t stb,
  output logic       swEnable,
  output logic       forceLowOn,
  output logic       forceAllOff,
  output logic       restartReq
);
  ctlState_t  state, nxtState;
  faultKind_t kind, nxtKind;
  logic       ovTrip, uvTrip, goRun;

  function automatic ctlState_t policyState(input logic [1:0] resp);
    return (resp == RESP_HICCUP) ? ST_HICCUP : ST_LATCH;
  endfunction

  assign ovTrip = ovDet && (ovResp != RESP_IGNORE);
  assign uvTrip = uvDet && (uvResp != RESP_IGNORE);

  always_comb begin
    nxtState = state;
    nxtKind  = kind;
    stb      = '0;
    goRun    = 1'b0;
    if (state == ST_RUN) begin
      if (ovTrip) begin
        nxtKind     = K_OV;
        nxtState    = policyState(ovResp);
        stb.hicLoad = 1'b1;
      end else if (uvTrip) begin
        nxtKind     = K_UV;
        nxtState    = policyState(uvResp);
        stb.hicLoad = 1'b1;
      end
    end else if (kind == K_UV && ovTrip) begin
      nxtKind     = K_OV;
      nxtState    = policyState(ovResp);
      stb.hicLoad = 1'b1;
    end else if (state == ST_LATCH) begin
      if (extReset && biasOk) begin
        nxtState = ST_RUN;
        goRun    = 1'b1;
      end
    end else begin
      if (hicDone) begin
        nxtState = ST_RUN;
        goRun    = 1'b1;
      end else begin
        stb.hicStep = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      kind       <= K_OV;
      restartReq <= 1'b0;
    end else begin
      state      <= nxtState;
      kind       <= nxtKind;
      restartReq <= goRun;
    end
  end

  assign swEnable    = (state == ST_RUN) && biasOk;
  assign forceLowOn  = (state != ST_RUN) && (kind == K_OV);
  assign forceAllOff = (state != ST_RUN) && (kind == K_UV);

  // R4
  ov_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceLowOn |-> (!swEnable && !forceAllOff));

  // R5
  uv_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceAllOff |-> (!swEnable && !forceLowOn));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH && !extReset) |=> (state != ST_RUN));

  // R8
  restart_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> (!forceLowOn && !forceAllOff));
endmodule

// File: rtl/vout_fault_ctrl.sv
`timescale 1ns/1ps
module vout_fault_ctrl
  import vfc_pkg::*;
#(
  parameter int FILT_W = 8,
  parameter int HIC_W  = 16,
  parameter int THR_W  = 8,
  parameter logic [THR_W-1:0] FIX_HI_CODE = 220,
  parameter logic [THR_W-1:0] FIX_LO_CODE = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              biasOk,
  input  logic              ssDone,
  input  logic              ovCmp,
  input  logic              uvCmp,
  input  logic [THR_W-1:0]  fbCode,
  input  logic              strapHi,
  input  logic [1:0]        ovResp,
  input  logic [1:0]        uvResp,
  input  logic              ovMask,
  input  logic              uvMask,
  input  logic [FILT_W-1:0] filtLen,
  input  logic [HIC_W-1:0]  hiccupLen,
  input  logic              clearFaults,
  input  logic              extReset,
  output logic              swEnable,
  output logic              forceLowOn,
  output logic              forceAllOff,
  output logic              restartReq,
  output logic              ovFlag,
  output logic              uvFlag,
  output logic              fixFlag,
  output logic              alert
);
  ctlStrobe_t stb;
  logic       ovDet, uvDet, hicDone;

  vfc_datapath #(
    .FILT_W(FILT_W), .HIC_W(HIC_W), .THR_W(THR_W),
    .FIX_HI_CODE(FIX_HI_CODE), .FIX_LO_CODE(FIX_LO_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .biasOk(biasOk), .ssDone(ssDone),
    .ovCmp(ovCmp), .uvCmp(uvCmp), .fbCode(fbCode), .strapHi(strapHi),
    .ovMask(ovMask), .uvMask(uvMask), .filtLen(filtLen),
    .hiccupLen(hiccupLen), .clearFaults(clearFaults), .stb(stb),
    .ovDet(ovDet), .uvDet(uvDet), .hicDone(hicDone),
    .ovFlag(ovFlag), .uvFlag(uvFlag), .fixFlag(fixFlag), .alert(alert)
  );

  vfc_control u_ctl (
    .clk(clk), .rstN(rstN), .biasOk(biasOk), .ovDet(ovDet), .uvDet(uvDet),
    .hicDone(hicDone), .ovResp(ovResp), .uvResp(uvResp), .extReset(extReset),
    .stb(stb), .swEnable(swEnable), .forceLowOn(forceLowOn),
    .forceAllOff(forceAllOff), .restartReq(restartReq)
  );
endmodule

// File: tb/vout_fault_ctrl_tb.sv
`timescale 1ns/1ps
module vout_fault_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       biasOk = 1'b1, ssDone = 1'b0, ovCmp = 1'b0, uvCmp = 1'b0;
  logic [7:0] fbCode = 8'd0;
  logic       strapHi = 1'b0;
  logic [1:0] ovResp = 2'd1, uvResp = 2'd1;
  logic       ovMask = 1'b0, uvMask = 1'b0;
  logic [7:0] filtLen = 8'd4;
  logic [15:0] hiccupLen = 16'd20;
  logic       clearFaults = 1'b0, extReset = 1'b0;
  logic       swEnable, forceLowOn, forceAllOff, restartReq;
  logic       ovFlag, uvFlag, fixFlag, alert;

  int total = 0;
  int bad = 0;
  int restarts = 0;

  always #4 clk = ~clk; // 125 MHz

  vout_fault_ctrl u_dut (
    .clk(clk), .rstN(rstN), .biasOk(biasOk), .ssDone(ssDone),
    .ovCmp(ovCmp), .uvCmp(uvCmp), .fbCode(fbCode), .strapHi(strapHi),
    .ovResp(ovResp), .uvResp(uvResp), .ovMask(ovMask), .uvMask(uvMask),
    .filtLen(filtLen), .hiccupLen(hiccupLen), .clearFaults(clearFaults),
    .extReset(extReset), .swEnable(swEnable), .forceLowOn(forceLowOn),
    .forceAllOff(forceAllOff), .restartReq(restartReq), .ovFlag(ovFlag),
    .uvFlag(uvFlag), .fixFlag(fixFlag), .alert(alert)
  );

  always @(negedge clk) if (rstN && restartReq) restarts++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0; strapHi = strap; biasOk = 1'b1; ssDone = 1'b0;
    ovCmp = 1'b0; uvCmp = 1'b0; fbCode = 8'd0; ovResp = 2'd1; uvResp = 2'd1;
    ovMask = 1'b0; uvMask = 1'b0; clearFaults = 1'b0; extReset = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(2);
  endtask

  task automatic t_reset;
    doReset(1'b0);
    check("R1", "swEnable", swEnable, 1);
    check("R1", "forceLowOn", forceLowOn, 0);
    check("R1", "forceAllOff", forceAllOff, 0);
    check("R1", "restartReq", restartReq, 0);
    check("R1", "flags+alert", {ovFlag, uvFlag, fixFlag, alert}, 0);
  endtask

  task automatic t_ovLatch;
    int r0;
    doReset(1'b0);
    ovCmp = 1'b1;              // soft-start not done
    tick(3);
    check("R9", "no early trip", forceLowOn, 0);
    tick(12);
    check("R2", "ovFlag before ssDone", ovFlag, 1);
    check("R4", "swEnable", swEnable, 0);
    check("R4", "forceLowOn", forceLowOn, 1);
    check("R4", "forceAllOff", forceAllOff, 0);
    check("R10", "alert", alert, 1);
    ovCmp = 1'b0;
    tick(60);
    check("R7", "latched hold", forceLowOn, 1);
    r0 = restarts;
    biasOk = 1'b0; extReset = 1'b1; tick(1); extReset = 1'b0; tick(3);
    check("R7", "reset ignored w/o bias", forceLowOn, 1);
    biasOk = 1'b1; tick(2);
    extReset = 1'b1; tick(1); extReset = 1'b0; tick(3);
    check("R7", "exit on reset", {swEnable, forceLowOn}, 2);
    check("R7", "restart pulses", restarts - r0, 1);
  endtask

  task automatic t_uvGateAndPreempt;
    doReset(1'b0);
    uvCmp = 1'b1;
    tick(20);
    check("R3", "uvFlag while ssDone low", uvFlag, 0);
    check("R3", "swEnable while ssDone low", swEnable, 1);
    ssDone = 1'b1;
    tick(12);
    check("R5", "forceAllOff", forceAllOff, 1);
    check("R5", "forceLowOn", forceLowOn, 0);
    check("R5", "swEnable", swEnable, 0);
    check("R5", "uvFlag", uvFlag, 1);
    ovCmp = 1'b1;
    tick(12);
    check("R13", "preempt forceLowOn", forceLowOn, 1);
    check("R13", "preempt forceAllOff", forceAllOff, 0);
  endtask

  task automatic t_ignoreAndSticky;
    doReset(1'b0);
    ovResp = 2'd0; uvResp = 2'd0; ssDone = 1'b1;
    ovCmp = 1'b1; uvCmp = 1'b1;
    tick(15);
    check("R6", "drive untouched", {swEnable, forceLowOn, forceAllOff}, 4);
    check("R6", "flags set", {ovFlag, uvFlag}, 3);
    ovCmp = 1'b0; uvCmp = 1'b0;
    tick(10);
    check("R10", "sticky flags", {ovFlag, uvFlag}, 3);
    ovMask = 1'b1; tick(1);
    check("R10", "alert uv only", alert, 1);
    uvMask = 1'b1; tick(1);
    check("R10", "alert all masked", alert, 0);
    check("R10", "flags kept under mask", {ovFlag, uvFlag}, 3);
    clearFaults = 1'b1; tick(1); clearFaults = 1'b0; tick(1);
    check("R10", "flags cleared", {ovFlag, uvFlag, fixFlag}, 0);
  endtask

  task automatic t_glitch;
    doReset(1'b0);
    ovCmp = 1'b1; tick(2); ovCmp = 1'b0;
    tick(15);
    check("R9", "short pulse flag", ovFlag, 0);
    check("R9", "short pulse drive", swEnable, 1);
  endtask

  task automatic t_hiccup;
    int r0;
    doReset(1'b0);
    uvResp = 2'd2; ssDone = 1'b1; uvCmp = 1'b1;
    tick(12);
    check("R8", "hiccup off", forceAllOff, 1);
    r0 = restarts;
    uvCmp = 1'b0; ssDone = 1'b0;
    tick(8);
    check("R8", "still off mid-hiccup", forceAllOff, 1);
    tick(30);
    check("R8", "restarted", {swEnable, forceAllOff}, 2);
    check("R8", "one restart pulse", restarts - r0, 1);
  endtask

  task automatic t_priority;
    doReset(1'b0);
    ssDone = 1'b1;
    ovCmp = 1'b1; uvCmp = 1'b1;
    tick(12);
    check("R11", "ov wins forceLowOn", forceLowOn, 1);
    check("R11", "ov wins forceAllOff", forceAllOff, 0);
    check("R11", "both flags", {ovFlag, uvFlag}, 3);
  endtask

  task automatic t_fixed;
    doReset(1'b1);
    fbCode = 8'd180;
    tick(12);
    check("R12", "hi strap below thr", {fixFlag, swEnable}, 1);
    fbCode = 8'd230;
    tick(12);
    check("R12", "hi strap above thr flag", fixFlag, 1);
    check("R12", "fixed uses ov drive", forceLowOn, 1);
    doReset(1'b0);
    strapHi = 1'b1;            // late change must not matter
    fbCode = 8'd180;
    tick(12);
    check("R12", "lo strap trips", fixFlag, 1);
    check("R12", "ov flag untouched", ovFlag, 0);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ovLatch();
    t_uvGateAndPreempt();
    t_ignoreAndSticky();
    t_glitch();
    t_hiccup();
    t_priority();
    t_fixed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule